// File: doc/BRIEF.md
# Radio Time-Code Frame Decoder

This block recovers the date and time from the demodulated on/off level of a low-frequency time broadcast. The carrier level enters asynchronously, is synchronised to the system clock, and is then handled only on cycles where the periodic sample tick is high. All time limits are counted in ticks. A glitch filter removes short spikes. A second slicer measures each low pulse from its falling edge. It classifies every second as a minute marker, a data second carrying an A bit, or a malformed second.

A frame builder collects the A bits of the 59 data seconds after a marker. When the next marker closes the frame, the builder checks the fixed trailer. If the trailer is correct, it publishes the BCD year, month, day of month, day of week, hour and minute together with a one-cycle strobe. The same marker opens the next frame in the same cycle. The B bits are never used. Status outputs report whether the decoder is locked to the minute, whether a frame was lost, and whether a malformed second or a bad trailer was seen.

Top module: `timecode_decoder`

## Requirements
- R1: A change of the synchronised carrier level that lasts fewer than `GLITCH_TICKS` consecutive ticks is ignored. A change that lasts `GLITCH_TICKS` ticks updates the filtered level.
- R2: A filtered falling edge starts a second. The A bit is the inverted filtered level `A_SAMPLE_TICKS` ticks after that edge (low = 1, high = 0). Further edges inside the second are not taken as new seconds until `SECOND_END_TICKS` ticks after the edge.
- R3: A second whose level is still low `MARK_MIN_TICKS` ticks after its falling edge is a minute marker.
- R4: A second is malformed if its leading low ends before `DATA_MIN_TICKS` ticks, or if the level is still low at `SECOND_END_TICKS`. A malformed second sets `code_err_o`, drops `in_sync_o` and discards the frame.
- R5: With the seconds after the marker numbered 1 to 59, the A bits map, most significant first, as: year BCD in 17–24, month in 25–29, day of month in 30–35, day of week in 36–38 (Monday=1 to Sunday=7), hour in 39–44, minute in 45–51. The A bits of seconds 1–16 are ignored.
- R6: The A bits of seconds 52–59 must read 0,1,1,1,1,1,1,0. On a mismatch nothing is published and `code_err_o` is set.
- R7: All six fields change together, only when a marker closes a frame of exactly 59 data seconds with a good trailer. `valid_o` is high for exactly that one cycle, and that marker also starts the next frame.
- R8: A marker arriving after fewer than 59 data seconds, or a 60th data second, discards the frame and sets `sync_lost_o`.
- R9: If no marker arrives within `TIMEOUT_TICKS` ticks of the previous marker while locked, `in_sync_o` falls and `sync_lost_o` is set.
- R10: After reset all fields are zero, and `valid_o`, `in_sync_o`, `sync_lost_o` and `code_err_o` are low.
- R11: An accepted frame clears `sync_lost_o` and `code_err_o`.
- R12: Data seconds received while not locked publish nothing and change no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample tick; all timing is counted in these |
| carrier | input | 1 | Demodulated carrier level, 1 = on |
| year_o | output | 8 | Year within century, BCD |
| month_o | output | 5 | Month, BCD |
| mday_o | output | 6 | Day of month, BCD |
| wday_o | output | 3 | Day of week, 1 = Monday … 7 = Sunday |
| hour_o | output | 6 | Hour, BCD |
| minute_o | output | 7 | Minute, BCD |
| valid_o | output | 1 | One-cycle strobe with each field update |
| in_sync_o | output | 1 | Locked to the minute marker |
| sync_lost_o | output | 1 | A frame was lost to an early marker, an overlong frame or a timeout |
| code_err_o | output | 1 | A malformed second or a bad trailer was seen |

## Verification
A single marker event both closes the running frame, which may publish, and opens the next one. So the strobe, the field update, the clearing of the error flags and the restart of the bit count and timeout all fall in one cycle. The bench provokes this with back-to-back frames, with a frame whose trailer is wrong followed by a good one, and with an early marker. A per-clock reference model predicts the exact cycle of the strobe and of every status transition, and compares all outputs against it.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  localparam int FRAME_BITS = 59;
  localparam logic [7:0] TRAILER = 8'b0111_1110;

  typedef enum logic [1:0] {
    EV_DATA = 2'd0,
    EV_MARK = 2'd1,
    EV_ERR  = 2'd2
  } ev_kind_t;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] mday;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] minute;
  } tod_t;

  // Bit for second s (1..59) sits at index FRAME_BITS - s.
  function automatic tod_t unpack_fields(input logic [FRAME_BITS-1:0] v);
    tod_t f;
    f.year   = v[42:35];
    f.month  = v[34:30];
    f.mday   = v[29:24];
    f.wday   = v[23:21];
    f.hour   = v[20:15];
    f.minute = v[14:8];
    return f;
  endfunction

  function automatic logic trailer_ok(input logic [FRAME_BITS-1:0] v);
    return v[7:0] == TRAILER;
  endfunction

endpackage

// File: rtl/tcd_glitch_filter.sv
module tcd_glitch_filter #(
  parameter int GLITCH_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(GLITCH_TICKS + 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      level <= 1'b1;
      run   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (tick) begin
        if (s2 == level) begin
          run <= '0;
        end else if (run == CW'(GLITCH_TICKS - 1)) begin
          level <= s2;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end

  // R1
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level));

endmodule

// File: rtl/tcd_second_slicer.sv
module tcd_second_slicer
  import tcd_pkg::*;
#(
  parameter int DATA_MIN_TICKS   = 80,
  parameter int A_SAMPLE_TICKS   = 150,
  parameter int MARK_MIN_TICKS   = 400,
  parameter int SECOND_END_TICKS = 900
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     level,
  output logic     ev_valid,
  output ev_kind_t ev_kind,
  output logic     ev_bit
);
  localparam int TW = $clog2(SECOND_END_TICKS + 1);

  logic          lvl_d, busy, rose, short_e, mark, abit;
  logic [TW-1:0] t;
  logic          fall_seen;
  logic          sec_end;

  assign fall_seen = tick && !busy && lvl_d && !level;
  assign sec_end   = tick && busy && (t == TW'(SECOND_END_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d    <= 1'b1;
      busy     <= 1'b0;
      rose     <= 1'b0;
      short_e  <= 1'b0;
      mark     <= 1'b0;
      abit     <= 1'b0;
      t        <= '0;
      ev_valid <= 1'b0;
      ev_kind  <= EV_DATA;
      ev_bit   <= 1'b0;
    end else begin
      ev_valid <= 1'b0;
      if (tick) begin
        lvl_d <= level;
        if (fall_seen) begin
          busy    <= 1'b1;
          t       <= TW'(1);
          rose    <= 1'b0;
          short_e <= 1'b0;
          mark    <= 1'b0;
          abit    <= 1'b0;
        end else if (busy) begin
          t <= t + 1'b1;
          if (level && !rose) begin
            rose <= 1'b1;
            if (t < TW'(DATA_MIN_TICKS)) short_e <= 1'b1;
          end
          if (t == TW'(A_SAMPLE_TICKS)) abit <= ~level;
          if (t == TW'(MARK_MIN_TICKS) && !level) mark <= 1'b1;
          if (sec_end) begin
            busy     <= 1'b0;
            ev_valid <= 1'b1;
            ev_bit   <= abit;
            if (short_e || !level) ev_kind <= EV_ERR;
            else if (mark)         ev_kind <= EV_MARK;
            else                   ev_kind <= EV_DATA;
          end
        end
      end
    end
  end

  // R2
  ev_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);

  // R2
  ev_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_end |=> ev_valid && !busy);

endmodule

// File: rtl/tcd_frame_builder.sv
module tcd_frame_builder
  import tcd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 61000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     ev_valid,
  input  ev_kind_t ev_kind,
  input  logic     ev_bit,
  output tod_t     fields,
  output logic     valid,
  output logic     in_sync,
  output logic     sync_lost,
  output logic     code_err
);
  localparam int MW = $clog2(TIMEOUT_TICKS + 1);
  localparam int NW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sr;
  logic [NW-1:0]         cnt;
  logic [MW-1:0]         tmo;
  logic ev_mark, ev_data, ev_err, frame_full, accept, tmo_hit;

  assign ev_mark    = ev_valid && (ev_kind == EV_MARK);
  assign ev_data    = ev_valid && (ev_kind == EV_DATA);
  assign ev_err     = ev_valid && (ev_kind == EV_ERR);
  assign frame_full = (cnt == NW'(FRAME_BITS));
  assign accept     = ev_mark && in_sync && frame_full && trailer_ok(sr);
  assign tmo_hit    = !ev_mark && tick && in_sync && (tmo == MW'(TIMEOUT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      tmo       <= '0;
      fields    <= '0;
      valid     <= 1'b0;
      in_sync   <= 1'b0;
      sync_lost <= 1'b0;
      code_err  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (ev_err) begin
        code_err <= 1'b1;
        in_sync  <= 1'b0;
      end
      if (ev_mark) begin
        if (in_sync) begin
          if (!frame_full)  sync_lost <= 1'b1;
          else if (!accept) code_err  <= 1'b1;
        end
        if (accept) begin
          fields    <= unpack_fields(sr);
          valid     <= 1'b1;
          sync_lost <= 1'b0;
          code_err  <= 1'b0;
        end
        in_sync <= 1'b1;
        cnt     <= '0;
      end
      if (ev_data && in_sync) begin
        if (frame_full) begin
          sync_lost <= 1'b1;
          in_sync   <= 1'b0;
        end else begin
          sr  <= {sr[FRAME_BITS-2:0], ev_bit};
          cnt <= cnt + 1'b1;
        end
      end
      if (ev_mark) begin
        tmo <= '0;
      end else if (tmo_hit) begin
        in_sync   <= 1'b0;
        sync_lost <= 1'b1;
        tmo       <= '0;
      end else if (tick && in_sync) begin
        tmo <= tmo + 1'b1;
      end
    end
  end

  // R7
  valid_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> in_sync);

  // R11
  valid_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !sync_lost && !code_err);

  // R7
  fields_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fields) |-> valid);

  // R9
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !in_sync && sync_lost);

endmodule

// File: rtl/timecode_decoder.sv
module timecode_decoder
  import tcd_pkg::*;
#(
  parameter int GLITCH_TICKS     = 20,
  parameter int DATA_MIN_TICKS   = 80,
  parameter int A_SAMPLE_TICKS   = 150,
  parameter int MARK_MIN_TICKS   = 400,
  parameter int SECOND_END_TICKS = 900,
  parameter int TIMEOUT_TICKS    = 61000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       carrier,
  output logic [7:0] year_o,
  output logic [4:0] month_o,
  output logic [5:0] mday_o,
  output logic [2:0] wday_o,
  output logic [5:0] hour_o,
  output logic [6:0] minute_o,
  output logic       valid_o,
  output logic       in_sync_o,
  output logic       sync_lost_o,
  output logic       code_err_o
);
  logic     level;
  logic     ev_valid, ev_bit;
  ev_kind_t ev_kind;
  tod_t     fields;

  tcd_glitch_filter #(.GLITCH_TICKS(GLITCH_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(carrier), .level(level)
  );

  tcd_second_slicer #(
    .DATA_MIN_TICKS(DATA_MIN_TICKS), .A_SAMPLE_TICKS(A_SAMPLE_TICKS),
    .MARK_MIN_TICKS(MARK_MIN_TICKS), .SECOND_END_TICKS(SECOND_END_TICKS)
  ) u_slice (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_bit(ev_bit)
  );

  tcd_frame_builder #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_bit(ev_bit),
    .fields(fields), .valid(valid_o), .in_sync(in_sync_o),
    .sync_lost(sync_lost_o), .code_err(code_err_o)
  );

  assign year_o   = fields.year;
  assign month_o  = fields.month;
  assign mday_o   = fields.mday;
  assign wday_o   = fields.wday;
  assign hour_o   = fields.hour;
  assign minute_o = fields.minute;

endmodule

// File: tb/sim_timecode_decoder.sv
module sim_timecode_decoder;
  localparam int G = 2, DMIN = 8, SA = 15, MMIN = 40, SEND = 90, TMO = 6100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, carrier = 1'b1;
  logic [7:0] year_o; logic [4:0] month_o; logic [5:0] mday_o;
  logic [2:0] wday_o; logic [5:0] hour_o; logic [6:0] minute_o;
  logic valid_o, in_sync_o, sync_lost_o, code_err_o;

  timecode_decoder #(
    .GLITCH_TICKS(G), .DATA_MIN_TICKS(DMIN), .A_SAMPLE_TICKS(SA),
    .MARK_MIN_TICKS(MMIN), .SECOND_END_TICKS(SEND), .TIMEOUT_TICKS(TMO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .carrier(carrier),
    .year_o(year_o), .month_o(month_o), .mday_o(mday_o), .wday_o(wday_o),
    .hour_o(hour_o), .minute_o(minute_o), .valid_o(valid_o),
    .in_sync_o(in_sync_o), .sync_lost_o(sync_lost_o), .code_err_o(code_err_o)
  );

  int n_chk = 0, n_err = 0, n_valid = 0, cyc = 0, phase = 0;
  bit lv_q[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---- behavioural reference model, one step per clock ----
  int m_s1, m_s2, m_lvl, m_run, m_lvd, m_busy, m_t, m_rose, m_short, m_mark, m_a;
  int m_ev, m_kind, m_bit, m_sync, m_lost, m_err, m_valid, m_tmo;
  bit m_bits[$];
  logic [34:0] m_f;

  function automatic int take(int first, int n);
    int v = 0;
    for (int k = 0; k < n; k++) v = v * 2 + m_bits[first - 1 + k];
    return v;
  endfunction

  task automatic model_step(input bit r, input bit tk, input bit cr);
    int was_sync;
    if (!r) begin
      m_s1 = 1; m_s2 = 1; m_lvl = 1; m_run = 0; m_lvd = 1; m_busy = 0; m_t = 0;
      m_rose = 0; m_short = 0; m_mark = 0; m_a = 0; m_ev = 0; m_kind = 0; m_bit = 0;
      m_sync = 0; m_lost = 0; m_err = 0; m_valid = 0; m_tmo = 0; m_f = '0;
      m_bits.delete();
      return;
    end
    was_sync = m_sync;
    m_valid = 0;
    if (m_ev == 1) begin
      if (m_kind == 2) begin m_err = 1; m_sync = 0; end
      else if (m_kind == 1) begin
        if (was_sync && m_bits.size() != 59) m_lost = 1;
        else if (was_sync && take(52, 8) != 8'h7E) m_err = 1;
        else if (was_sync) begin
          m_f = {8'(take(17, 8)), 5'(take(25, 5)), 6'(take(30, 6)),
                 3'(take(36, 3)), 6'(take(39, 6)), 7'(take(45, 7))};
          m_valid = 1; m_lost = 0; m_err = 0;
        end
        m_sync = 1; m_bits.delete();
      end else if (was_sync) begin
        if (m_bits.size() == 59) begin m_lost = 1; m_sync = 0; end
        else m_bits.push_back(m_bit[0]);
      end
    end
    if (m_ev == 1 && m_kind == 1) m_tmo = 0;
    else if (tk && was_sync) begin
      if (m_tmo == TMO - 1) begin m_sync = 0; m_lost = 1; m_tmo = 0; end
      else m_tmo++;
    end
    m_ev = 0;
    if (tk) begin
      if (!m_busy && m_lvd == 1 && m_lvl == 0) begin
        m_busy = 1; m_t = 1; m_rose = 0; m_short = 0; m_mark = 0; m_a = 0;
      end else if (m_busy) begin
        if (m_t == SEND) begin
          m_busy = 0; m_ev = 1; m_bit = m_a;
          m_kind = (m_short || m_lvl == 0) ? 2 : (m_mark ? 1 : 0);
        end
        if (m_lvl == 1 && !m_rose) begin m_rose = 1; if (m_t < DMIN) m_short = 1; end
        if (m_t == SA) m_a = 1 - m_lvl;
        if (m_t == MMIN && m_lvl == 0) m_mark = 1;
        m_t++;
      end
      m_lvd = m_lvl;
      if (m_s2 == m_lvl) m_run = 0;
      else if (m_run == G - 1) begin m_lvl = m_s2; m_run = 0; end
      else m_run++;
    end
    m_s2 = m_s1; m_s1 = cr;
  endtask

  always @(negedge clk) begin
    cyc++;
    model_step(rst_n, tick, carrier);
    check(valid_o == m_valid[0], "R7", "valid_o", valid_o, m_valid);
    check(in_sync_o == m_sync[0], "R9", "in_sync_o", in_sync_o, m_sync);
    check(sync_lost_o == m_lost[0], "R8", "sync_lost_o", sync_lost_o, m_lost);
    check(code_err_o == m_err[0], "R4", "code_err_o", code_err_o, m_err);
    check({year_o, month_o, mday_o, wday_o, hour_o, minute_o} == m_f, "R5", "fields",
          {year_o, month_o, mday_o, wday_o, hour_o, minute_o}, m_f);
    if (valid_o) n_valid++;
    rst_n <= (cyc >= 6);
    if (phase == 0) begin
      carrier <= (lv_q.size() > 0) ? lv_q.pop_front() : 1'b1;
      tick <= 1'b0; phase = 1;
    end else begin
      tick <= 1'b1; phase = 0;
    end
  end

  // ---- stimulus ----
  task automatic push(input bit l, input int n);
    for (int i = 0; i < n; i++) lv_q.push_back(l);
  endtask

  task automatic send_marker();
    push(0, 50); push(1, 50);
  endtask

  task automatic send_sec(input bit a, input bit b, input bit spiky);
    if (spiky) begin push(0, 5); push(1, 1); push(0, 4); end
    else push(0, 10);
    push(!a, 10); push(!b, 10);
    if (spiky) begin push(1, 30); push(0, 1); push(1, 39); end
    else push(1, 70);
  endtask

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  task automatic send_frame(input int yr, input int mo, input int dm, input int dw,
                            input int hr, input int mn, input logic [7:0] tr, input bit spiky);
    logic [7:0] yb, mb, db, hb, nb;
    logic [58:0] v;
    yb = bcd(yr); mb = bcd(mo); db = bcd(dm); hb = bcd(hr); nb = bcd(mn);
    v = {16'hA5C3, yb, mb[4:0], db[5:0], 3'(dw), hb[5:0], nb[6:0], tr};
    for (int s = 1; s <= 59; s++) send_sec(v[59 - s], (s <= 16) && (s % 3 == 0), spiky);
  endtask

  task automatic drain();
    wait (lv_q.size() == 0);
    repeat (24) @(negedge clk);
  endtask

  task automatic check_date(input string req, input int yr, input int mo, input int dm,
                            input int dw, input int hr, input int mn);
    logic [7:0] yb, mb, db, hb, nb;
    yb = bcd(yr); mb = bcd(mo); db = bcd(dm); hb = bcd(hr); nb = bcd(mn);
    check(year_o == yb, req, "year", year_o, yb);
    check(month_o == mb[4:0], req, "month", month_o, mb[4:0]);
    check(mday_o == db[5:0], req, "mday", mday_o, db[5:0]);
    check(wday_o == 3'(dw), req, "wday", wday_o, dw);
    check(hour_o == hb[5:0], req, "hour", hour_o, hb[5:0]);
    check(minute_o == nb[6:0], req, "minute", minute_o, nb[6:0]);
  endtask

  initial begin
    wait (rst_n == 1'b1);
    @(negedge clk);
    // R10 reset state
    check({year_o, month_o, mday_o, wday_o, hour_o, minute_o} == 35'd0, "R10", "fields", 0, 0);
    check(!valid_o && !in_sync_o && !sync_lost_o && !code_err_o, "R10", "status",
          {valid_o, in_sync_o, sync_lost_o, code_err_o}, 0);
    push(1, 100);
    // R12 data seconds while unlocked
    for (int i = 0; i < 10; i++) send_sec(i % 2, 0, 0);
    drain();
    check(n_valid == 0 && !in_sync_o && !code_err_o, "R12", "unlocked data", n_valid, 0);
    // R2 R3 R5 R7 first frame
    send_marker();
    send_frame(24, 2, 29, 4, 23, 59, 8'h7E, 0);
    send_marker();
    drain();
    check(n_valid == 1, "R7", "strobes", n_valid, 1);
    check(in_sync_o == 1'b1, "R3", "locked", in_sync_o, 1);
    check_date("R5", 24, 2, 29, 4, 23, 59);
    // R1 spiky frame, back-to-back
    send_frame(99, 12, 31, 7, 0, 0, 8'h7E, 1);
    send_marker();
    drain();
    check(n_valid == 2, "R1", "strobes", n_valid, 2);
    check_date("R1", 99, 12, 31, 7, 0, 0);
    // R6 bad trailer
    send_frame(11, 11, 11, 3, 11, 11, 8'h7F, 0);
    send_marker();
    drain();
    check(n_valid == 2 && code_err_o, "R6", "no publish", n_valid, 2);
    check_date("R6", 99, 12, 31, 7, 0, 0);
    // R11 good frame clears error
    send_frame(7, 10, 5, 1, 9, 30, 8'h7E, 0);
    send_marker();
    drain();
    check(n_valid == 3 && !code_err_o, "R11", "err cleared", code_err_o, 0);
    check_date("R2", 7, 10, 5, 1, 9, 30);
    // R4 short pulse
    for (int i = 0; i < 20; i++) send_sec(1, 1, 0);
    push(0, 5); push(1, 95);
    for (int i = 0; i < 3; i++) send_sec(0, 0, 0);
    drain();
    check(code_err_o && !in_sync_o, "R4", "short pulse", {code_err_o, in_sync_o}, 2);
    // R8 early marker
    send_marker();
    for (int i = 0; i < 30; i++) send_sec(0, 1, 0);
    send_marker();
    drain();
    check(sync_lost_o && in_sync_o, "R8", "early marker", {sync_lost_o, in_sync_o}, 3);
    send_frame(30, 6, 15, 6, 12, 45, 8'h7E, 0);
    send_marker();
    drain();
    check(n_valid == 4 && !sync_lost_o && !code_err_o, "R11", "flags cleared", n_valid, 4);
    check_date("R7", 30, 6, 15, 6, 12, 45);
    // R9 timeout
    push(1, TMO + 100);
    drain();
    check(!in_sync_o && sync_lost_o, "R9", "timeout", {in_sync_o, sync_lost_o}, 1);
    check_date("R9", 30, 6, 15, 6, 12, 45);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule